// File: doc/BRIEF.md
# Carry-Select Adder-Subtractor with Counter Register

This block adds or subtracts two unsigned operands of a parameterised width through a chain of one-bit cells grouped into clusters of ten. Each cell carries two ripple chains side by side: one built on the assumption that the incoming carry is 0 and one on the assumption that it is 1. Within each cluster the true carry is resolved only at the fifth and tenth cells. A two-way select there picks the sum bits and the outgoing carry for that group of five cells. The resolved carry of one group becomes the select of the next, so the worst-case path crosses one select per five bits rather than one carry stage per bit.

A mode input turns the adder into a subtractor. In subtract mode the B operand is inverted and the carry into bit 0 is forced high, which yields A - B in two's complement. The combinational result is also captured into a pipeline register on every clock. A separate counter register, built around a second instance of the same chain, offers clear, load, count enable and up/down control. Clear has the highest priority, then load, then counting.

Top module: `csel_addsub_chain`

## Requirements
- R1: With `sub`=0, `{cout,sum}` equals `a + b + cin` as an unsigned (WIDTH+1)-bit value, combinationally. This includes carries that cross the five-cell group edges (bit 4 to 5, 9 to 10) and the cluster edges, and the overflow of all-ones operands.
- R2: With `sub`=1, `sum` equals `(a - b) mod 2^WIDTH`, and `cin` has no effect on `sum` or `cout`.
- R3: With `sub`=1, `cout` is 1 exactly when `a >= b` as unsigned values, and 0 when a borrow occurs.
- R4: `sum_r` and `cout_r` hold the values `sum` and `cout` had just before the most recent rising clock edge.
- R5: `sclr`=1 makes `q` zero after the next rising edge, regardless of `sload` and `cnt_en`.
- R6: `sload`=1 with `sclr`=0 makes `q` equal `a` after the next rising edge, regardless of `cnt_en`.
- R7: `cnt_en`=1 and `cnt_down`=0, with no clear or load, increments `q` by one per edge, and all-ones wraps to zero.
- R8: `cnt_en`=1 and `cnt_down`=1, with no clear or load, decrements `q` by one per edge, and zero wraps to all-ones.
- R9: With `sclr`, `sload` and `cnt_en` all 0, `q` keeps its value.
- R10: While `rst_n` is 0, `q`, `sum_r` and `cout_r` are 0. After `rst_n` rises, the registers stay in reset for the first two rising edges and respond to commands from the third edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a | input | WIDTH | Operand A; also the load value for the counter |
| b | input | WIDTH | Operand B |
| sub | input | 1 | 1 selects A - B, 0 selects A + B |
| cin | input | 1 | Carry into bit 0 in add mode |
| cnt_en | input | 1 | Counter step enable |
| cnt_down | input | 1 | Counter direction, 1 counts down |
| sclr | input | 1 | Synchronous counter clear |
| sload | input | 1 | Synchronous counter load from `a` |
| sum | output | WIDTH | Combinational sum or difference |
| cout | output | 1 | Combinational carry-out (no-borrow in subtract mode) |
| sum_r | output | WIDTH | Registered `sum` |
| cout_r | output | 1 | Registered `cout` |
| q | output | WIDTH | Counter register |

## Verification
`sum` and `cout` settle within the same cycle as the operands. The bench therefore drives inputs on the falling edge and compares one time unit later, with no clock edge in between. `sum_r`, `cout_r` and `q` change on the first rising edge after the stimulus, so each register check drives on a falling edge and compares at the next falling edge, exactly one rising edge later. The reset test counts edges after release: it expects `q` to still be zero after the second rising edge and to show the loaded value after the third.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int CLUSTER_CELLS = 10;
  localparam int GROUP_CELLS   = CLUSTER_CELLS / 2;

  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_COUNT = 2'd1,
    CMD_LOAD  = 2'd2,
    CMD_CLEAR = 2'd3
  } reg_cmd_e;
endpackage

// File: rtl/csel_rst_sync.sv
module csel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign srst_n = stage_q[STAGES-1];
endmodule

// File: rtl/csel_cell.sv
// One bit position with two independent carry chains.
module csel_cell (
  input  logic d1,
  input  logic d2,
  input  logic ci0,
  input  logic ci1,
  output logic s0,
  output logic s1,
  output logic co0,
  output logic co1
);
  logic prop;
  logic gen;

  always_comb begin
    prop = d1 ^ d2;
    gen  = d1 & d2;
    s0   = prop ^ ci0;
    s1   = prop ^ ci1;
    co0  = gen | (prop & ci0);
    co1  = gen | (prop & ci1);
  end
endmodule

// File: rtl/csel_group.sv
// A run of cells whose two chains start at 0 and 1; the resolved carry selects.
module csel_group #(
  parameter int CELLS = 5
) (
  input  logic [CELLS-1:0] d1,
  input  logic [CELLS-1:0] d2,
  input  logic             csel,
  output logic [CELLS-1:0] s,
  output logic             co
);
  logic [CELLS:0]   chain0;
  logic [CELLS:0]   chain1;
  logic [CELLS-1:0] s0;
  logic [CELLS-1:0] s1;

  assign chain0[0] = 1'b0;
  assign chain1[0] = 1'b1;

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    csel_cell u_cell (
      .d1  (d1[i]),
      .d2  (d2[i]),
      .ci0 (chain0[i]),
      .ci1 (chain1[i]),
      .s0  (s0[i]),
      .s1  (s1[i]),
      .co0 (chain0[i+1]),
      .co1 (chain1[i+1])
    );
  end

  always_comb begin
    s  = csel ? s1 : s0;
    co = csel ? chain1[CELLS] : chain0[CELLS];
  end
endmodule

// File: rtl/csel_chain.sv
// Full-width adder-subtractor built from five-cell groups (two per cluster).
module csel_chain
  import csel_pkg::*;
#(
  parameter int WIDTH = 24
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NGROUP = (WIDTH + GROUP_CELLS - 1) / GROUP_CELLS;

  logic [WIDTH-1:0] b_eff;
  logic [NGROUP:0]  gcarry;

  always_comb begin
    b_eff = b ^ {WIDTH{sub}};
  end

  // Bit 0 is the first cell of the first cluster: the mode input owns its carry.
  assign gcarry[0] = sub | cin;

  for (genvar g = 0; g < NGROUP; g++) begin : g_grp
    localparam int LO = g * GROUP_CELLS;
    localparam int NC = ((WIDTH - LO) < GROUP_CELLS) ? (WIDTH - LO) : GROUP_CELLS;
    csel_group #(.CELLS(NC)) u_grp (
      .d1   (a[LO +: NC]),
      .d2   (b_eff[LO +: NC]),
      .csel (gcarry[g]),
      .s    (sum[LO +: NC]),
      .co   (gcarry[g+1])
    );
  end

  assign cout = gcarry[NGROUP];
endmodule

// File: rtl/csel_addsub_chain.sv
module csel_addsub_chain
  import csel_pkg::*;
#(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  input  logic             cin,
  input  logic             cnt_en,
  input  logic             cnt_down,
  input  logic             sclr,
  input  logic             sload,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic [WIDTH-1:0] sum_r,
  output logic             cout_r,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] STEP = {{(WIDTH-1){1'b0}}, 1'b1};

  logic             srst_n;
  logic [WIDTH-1:0] step_sum;
  logic             step_co;
  logic [WIDTH-1:0] q_d;
  logic             q_en;
  reg_cmd_e         cmd;

  csel_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  csel_chain #(.WIDTH(WIDTH)) u_main (
    .a    (a),
    .b    (b),
    .sub  (sub),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
  );

  csel_chain #(.WIDTH(WIDTH)) u_step (
    .a    (q),
    .b    (STEP),
    .sub  (cnt_down),
    .cin  (1'b0),
    .sum  (step_sum),
    .cout (step_co)
  );

  always_comb begin
    if (sclr)        cmd = CMD_CLEAR;
    else if (sload)  cmd = CMD_LOAD;
    else if (cnt_en) cmd = CMD_COUNT;
    else             cmd = CMD_HOLD;
  end

  always_comb begin
    q_en = 1'b1;
    q_d  = q;
    unique case (cmd)
      CMD_CLEAR: q_d = '0;
      CMD_LOAD:  q_d = a;
      CMD_COUNT: q_d = step_sum;
      default:   q_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)   q <= '0;
    else if (q_en) q <= q_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      sum_r  <= '0;
      cout_r <= 1'b0;
    end else begin
      sum_r  <= sum;
      cout_r <= cout;
    end
  end

  logic unused_step_co;
  assign unused_step_co = step_co;
endmodule

// File: rtl/csel_addsub_chain_chk.sv
module csel_addsub_chain_chk #(
  parameter int WIDTH = 24
) (
  input logic             clk,
  input logic             srst_n,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             sub,
  input logic             cin,
  input logic             cnt_en,
  input logic             cnt_down,
  input logic             sclr,
  input logic             sload,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic [WIDTH-1:0] sum_r,
  input logic             cout_r,
  input logic [WIDTH-1:0] q
);
  AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!srst_n)
    !sub |-> ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))); // R1
  AST_SUB_RESULT: assert property (@(posedge clk) disable iff (!srst_n)
    sub |-> (sum == (a - b))); // R2
  AST_SUB_BORROW: assert property (@(posedge clk) disable iff (!srst_n)
    sub |-> (cout == (a >= b))); // R3
  AST_REG_SUM: assert property (@(posedge clk) disable iff (!srst_n)
    1'b1 |=> (sum_r == $past(sum)) && (cout_r == $past(cout))); // R4
  AST_CLEAR: assert property (@(posedge clk) disable iff (!srst_n)
    sclr |=> (q == '0)); // R5
  AST_LOAD: assert property (@(posedge clk) disable iff (!srst_n)
    (!sclr && sload) |=> (q == $past(a))); // R6
  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!srst_n)
    (!sclr && !sload && cnt_en && !cnt_down) |=> (q == $past(q) + 1'b1)); // R7
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!srst_n)
    (!sclr && !sload && cnt_en && cnt_down) |=> (q == $past(q) - 1'b1)); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    (!sclr && !sload && !cnt_en) |=> $stable(q)); // R9
endmodule

bind csel_addsub_chain csel_addsub_chain_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .srst_n   (srst_n),
  .a        (a),
  .b        (b),
  .sub      (sub),
  .cin      (cin),
  .cnt_en   (cnt_en),
  .cnt_down (cnt_down),
  .sclr     (sclr),
  .sload    (sload),
  .sum      (sum),
  .cout     (cout),
  .sum_r    (sum_r),
  .cout_r   (cout_r),
  .q        (q)
);

// File: tb/tb_csel_addsub_chain.sv
module tb_csel_addsub_chain;
  localparam int W = 24;
  localparam int CLK_PERIOD = 10;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk;
  logic rst_n;
  logic [W-1:0] a, b;
  logic sub, cin, cnt_en, cnt_down, sclr, sload;
  logic [W-1:0] sum, sum_r, q;
  logic cout, cout_r;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;

  csel_addsub_chain #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .sub(sub), .cin(cin),
    .cnt_en(cnt_en), .cnt_down(cnt_down), .sclr(sclr), .sload(sload),
    .sum(sum), .cout(cout), .sum_r(sum_r), .cout_r(cout_r), .q(q)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_ctrl();
    cnt_en = 0; cnt_down = 0; sclr = 0; sload = 0;
  endtask

  task automatic comb_add(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    logic [W:0] e;
    @(negedge clk);
    a = x; b = y; cin = c; sub = 0;
    #1;
    e = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    check("R1 add", {cout, sum}, e);
  endtask

  task automatic comb_sub(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    logic [W-1:0] d;
    @(negedge clk);
    a = x; b = y; cin = c; sub = 1;
    #1;
    d = x - y;
    check("R2 sub", sum, d);
    check("R3 borrow", cout, (x >= y));
  endtask

  task automatic t_reset();
    rst_n = 0; a = 0; b = 0; sub = 0; cin = 0; idle_ctrl();
    repeat (3) @(negedge clk);
    a = 7; b = 9;
    #1;
    check("R10 q in reset", q, 0);
    check("R10 sum_r in reset", sum_r, 0);
    check("R10 cout_r in reset", cout_r, 0);
    rst_n = 1; sload = 1; a = 5;
    @(negedge clk); @(negedge clk);
    check("R10 q after two edges", q, 0);
    @(negedge clk);
    check("R10 q after third edge", q, 5);
    idle_ctrl();
  endtask

  task automatic t_add();
    comb_add(0, 0, 0);
    comb_add(ONES, 24'h1, 0);
    comb_add(ONES, ONES, 1);
    comb_add(ONES, 0, 1);
    comb_add(24'h00001F, 24'h1, 0);
    comb_add(24'h0003FF, 0, 1);
    comb_add(24'h0FFFFF, 24'h0FFFFF, 0);
    for (int i = 0; i < 100; i++) comb_add(W'($urandom()), W'($urandom()), 1'($urandom()));
  endtask

  task automatic t_sub();
    comb_sub(24'h123456, 24'h123456, 0);
    comb_sub(0, 24'h1, 0);
    comb_sub(0, 24'h1, 1);
    comb_sub(ONES, ONES, 1);
    comb_sub(0, 0, 0);
    comb_sub(24'h000400, 24'h000001, 0);
    for (int i = 0; i < 100; i++) comb_sub(W'($urandom()), W'($urandom()), 1'($urandom()));
  endtask

  task automatic t_regsum();
    logic [W:0] e;
    @(negedge clk);
    a = ONES; b = 24'h2; sub = 0; cin = 0;
    e = {1'b0, ONES} + 25'h2;
    @(negedge clk);
    a = 24'h11; b = 24'h22;
    #1;
    check("R4 sum_r", sum_r, e[W-1:0]);
    check("R4 cout_r", cout_r, e[W]);
    @(negedge clk);
    check("R4 sum_r next", sum_r, 24'h33);
    check("R4 cout_r next", cout_r, 0);
  endtask

  task automatic t_clear_load();
    @(negedge clk); idle_ctrl(); sload = 1; a = 24'hABCDEF; cnt_en = 1;
    @(negedge clk);
    check("R6 load over count", q, 24'hABCDEF);
    sclr = 1; sload = 1; a = 24'h1;
    @(negedge clk);
    check("R5 clear over load", q, 0);
    idle_ctrl(); a = 24'h55;
    repeat (3) @(negedge clk);
    check("R9 hold", q, 0);
  endtask

  task automatic t_count();
    @(negedge clk); idle_ctrl(); sload = 1; a = ONES - 1;
    @(negedge clk); idle_ctrl(); cnt_en = 1;
    @(negedge clk);
    check("R7 up", q, ONES);
    @(negedge clk);
    check("R7 wrap", q, 0);
    cnt_down = 1;
    @(negedge clk);
    check("R8 down wrap", q, ONES);
    @(negedge clk);
    check("R8 down", q, ONES - 1);
    idle_ctrl(); sload = 1; a = 24'h000A00;
    @(negedge clk); idle_ctrl(); cnt_en = 1; cnt_down = 1;
    @(negedge clk);
    check("R8 borrow across group", q, 24'h0009FF);
    cnt_down = 0;
    @(negedge clk);
    check("R7 carry across group", q, 24'h000A00);
    idle_ctrl(); a = 24'h777;
    @(negedge clk); @(negedge clk);
    check("R9 hold after count", q, 24'h000A00);
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_regsum();
    t_clear_load();
    t_count();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule